// File: doc/BRIEF.md
# Buffered Compare Channel for a 10-bit Timer

This block is one compare channel beside a 10-bit up/down timer. It watches the running count, and whenever the count equals the active compare value it sends a one-cycle match pulse to a downstream waveform generator. On the same clock edge it sets a sticky flag. If the channel's interrupt is enabled, that flag raises an interrupt request. The flag clears when the interrupt controller acknowledges it, or when software writes a one to the flag bit.

Software reaches the channel over an 8-bit register bus. The upper bits of the compare value go through a shared staging register. Software loads the staging register first. A write of the low byte then joins both parts into the full value. A read of the low byte returns the active value and copies its upper bits into the staging register. In normal mode a compare write takes effect at once. In PWM mode the write goes into a buffer. The active value loads from that buffer only at the counting boundary picked by a select input, so no pulse of odd length can appear. A force strobe sends a match pulse without touching the flag.

Top module: `ocu_channel`

## Requirements
- R1: When `count` equals the active compare value in a cycle, `match_evt` is high for the following cycle.
- R2: An equality sets the flag at the next clock edge, not in the cycle of equality. The flag reads back as bit 0 of register address 2.
- R3: `irq` is high exactly when the flag is set and the interrupt enable is set. The interrupt enable is bit 1 of address 2, written and read at that position.
- R4: A pulse on `irq_ack` clears the flag.
- R5: Writing address 2 with bit 0 = 1 clears the flag, and bit 0 = 0 leaves it unchanged. If a new equality falls in the same cycle as any clear, the flag stays set.
- R6: With `pwm_en` high, a compare write lands in the buffer only. The active value loads from the buffer on `at_top` when `upd_sel` = 0, or on `at_bottom` when `upd_sel` = 1, and the other strobe has no effect.
- R7: With `pwm_en` low, a compare write updates the active value at once.
- R8: Address 1 holds the staging bits 9:8 in data bits 1:0. A write to address 0 forms the compare value as {staging, wdata}.
- R9: A read of address 0 returns the low byte of the active value, not the buffer. It also copies active bits 9:8 into the staging register.
- R10: A pulse on `force_cmp` produces a `match_evt` pulse one cycle later. It neither sets the flag nor raises `irq`.
- R11: In PWM mode, when a compare write and the selected boundary happen in the same cycle, the active value loads the old buffer. The new value stays in the buffer until the next boundary.
- R12: After reset the compare value, buffer, staging register, flag and interrupt enable are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count | input | 10 | Running timer count |
| at_top | input | 1 | Counter reached its top value |
| at_bottom | input | 1 | Counter reached zero |
| pwm_en | input | 1 | A PWM mode is active (enables buffering) |
| upd_sel | input | 1 | Buffered update boundary: 0 top, 1 bottom |
| force_cmp | input | 1 | Force a match event |
| irq_ack | input | 1 | Interrupt serviced, clears the flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 compare low, 1 staging high, 2 control/status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when `rd_en` is low |
| match_evt | output | 1 | Match pulse to the waveform generator |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level rules on every clock. These are: the pulse and the flag follow an equality by one edge, acknowledge and write-one clears take effect, the active value holds still in PWM mode away from the selected boundary, direct writes in normal mode, and a forced compare produces a pulse. The bench scenarios are needed for the register-level behaviour. This covers joining the staging bits with the low byte, the staging copy made by a read, a write with bit 0 = 0 leaving the flag alone, the update that lands one boundary late when a write meets the boundary, and the rule that a forced compare never shows up on `irq`.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  typedef enum logic [1:0] {
    REG_CMP_LO = 2'd0,
    REG_CMP_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_NONE   = 2'd3
  } ocu_reg_e;

  localparam int CTRL_FLAG_BIT = 0;
  localparam int CTRL_IEN_BIT  = 1;

endpackage

// File: rtl/ocu_regbus.sv
module ocu_regbus
  import ocu_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] active_val,
  input  logic             flag,
  output logic [BUS_W-1:0] rdata,
  output logic             wr_cmp,
  output logic [CNT_W-1:0] wr_cmp_val,
  output logic             clr_req,
  output logic             ien
);

  localparam int HI_W = CNT_W - BUS_W;

  logic [HI_W-1:0] staging;
  logic            wr_hi, rd_lo, wr_ctrl;

  function automatic logic [CNT_W-1:0] join_value(input logic [HI_W-1:0] hi,
                                                  input logic [BUS_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign wr_cmp     = wr_en && (addr == REG_CMP_LO);
  assign wr_hi      = wr_en && (addr == REG_CMP_HI);
  assign wr_ctrl    = wr_en && (addr == REG_CTRL);
  assign rd_lo      = rd_en && (addr == REG_CMP_LO);
  assign wr_cmp_val = join_value(staging, wdata);
  assign clr_req    = wr_ctrl && wdata[CTRL_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staging <= '0;
      ien     <= 1'b0;
    end else begin
      if (wr_hi)      staging <= wdata[HI_W-1:0];
      else if (rd_lo) staging <= active_val[CNT_W-1:BUS_W];
      if (wr_ctrl)    ien <= wdata[CTRL_IEN_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        REG_CMP_LO: rdata = active_val[BUS_W-1:0];
        REG_CMP_HI: rdata[HI_W-1:0] = staging;
        REG_CTRL: begin
          rdata[CTRL_FLAG_BIT] = flag;
          rdata[CTRL_IEN_BIT]  = ien;
        end
        default: rdata = '0;
      endcase
    end
  end

  // R9: a low-byte read leaves the active upper bits in staging
  p_stage_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> staging == $past(active_val[CNT_W-1:BUS_W]));

  // R8: a high-byte write lands in staging
  p_stage_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> staging == $past(wdata[HI_W-1:0]));

endmodule

// File: rtl/ocu_cmpbuf.sv
module ocu_cmpbuf #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_en,
  input  logic             upd_sel,
  input  logic             at_top,
  input  logic             at_bottom,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] active
);

  logic [CNT_W-1:0] shadow;
  logic             boundary;
  logic             load_shadow;

  function automatic logic pick_boundary(input logic sel, input logic top,
                                         input logic bot);
    return sel ? bot : top;
  endfunction

  assign boundary    = pick_boundary(upd_sel, at_top, at_bottom);
  assign load_shadow = pwm_en && boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (wr_cmp) shadow <= wr_val;
      if (!pwm_en) begin
        if (wr_cmp) active <= wr_val;
      end else if (load_shadow) begin
        active <= shadow;
      end
    end
  end

  // R6: no change away from the selected boundary in PWM mode
  p_pwm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !boundary) |=> $stable(active));

  // R6: boundary loads the buffered value
  p_pwm_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && boundary) |=> active == $past(shadow));

  // R7: direct update in normal mode
  p_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_en && wr_cmp) |=> active == $past(wr_val));

  // R11: a write meeting the boundary is kept in the buffer
  p_coincide_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_shadow && wr_cmp) |=> shadow == $past(wr_val));

endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] active,
  input  logic             force_cmp,
  input  logic             irq_ack,
  input  logic             clr_req,
  output logic             match_now,
  output logic             match_evt,
  output logic             flag
);

  function automatic logic is_equal(input logic [CNT_W-1:0] a,
                                    input logic [CNT_W-1:0] b);
    return a == b;
  endfunction

  assign match_now = is_equal(count, active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_evt <= 1'b0;
      flag      <= 1'b0;
    end else begin
      match_evt <= match_now || force_cmp;
      if (match_now)               flag <= 1'b1;
      else if (irq_ack || clr_req) flag <= 1'b0;
    end
  end

  // R1: equality yields an event pulse one cycle later
  p_evt_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    match_now |=> match_evt);

  // R2: flag set one edge after equality
  p_flag_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_now |=> flag);

  // R2 / R10: only a real equality raises the flag
  p_flag_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match_now));

  // R4: acknowledge clears
  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !match_now) |=> !flag);

  // R5: write-one clears
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !match_now) |=> !flag);

  // R10: forced compare produces an event
  p_force_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    force_cmp |=> match_evt);

endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
  import ocu_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             at_top,
  input  logic             at_bottom,
  input  logic             pwm_en,
  input  logic             upd_sel,
  input  logic             force_cmp,
  input  logic             irq_ack,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             match_evt,
  output logic             irq
);

  logic [CNT_W-1:0] active_val;
  logic [CNT_W-1:0] wr_cmp_val;
  logic             wr_cmp, clr_req, ien, flag, match_now;

  ocu_regbus #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regbus (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .active_val(active_val), .flag(flag), .rdata(rdata),
    .wr_cmp(wr_cmp), .wr_cmp_val(wr_cmp_val), .clr_req(clr_req), .ien(ien)
  );

  ocu_cmpbuf #(.CNT_W(CNT_W)) u_cmpbuf (
    .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .upd_sel(upd_sel),
    .at_top(at_top), .at_bottom(at_bottom), .wr_cmp(wr_cmp),
    .wr_val(wr_cmp_val), .active(active_val)
  );

  ocu_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .count(count), .active(active_val),
    .force_cmp(force_cmp), .irq_ack(irq_ack), .clr_req(clr_req),
    .match_now(match_now), .match_evt(match_evt), .flag(flag)
  );

  assign irq = flag && ien;

  // R3: the request never rises without an enabled, set flag one cycle earlier source
  p_irq_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(match_now) || $past(wr_en && addr == REG_CTRL)));

endmodule

// File: tb/ocu_channel_test.sv
module ocu_channel_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] count = 10'h3FF;
  logic       at_top = 0, at_bottom = 0, pwm_en = 0, upd_sel = 0;
  logic       force_cmp = 0, irq_ack = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 2'd3;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       match_evt, irq;

  always #2.5 clk = ~clk;

  ocu_channel uut (
    .clk(clk), .rst_n(rst_n), .count(count), .at_top(at_top),
    .at_bottom(at_bottom), .pwm_en(pwm_en), .upd_sel(upd_sel),
    .force_cmp(force_cmp), .irq_ack(irq_ack), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .match_evt(match_evt), .irq(irq)
  );

  typedef struct {
    int    sel;
    int    exp;
    string tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 0;

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      item_t it;
      int    act;
      wait (sb.size() != 0);
      it  = sb.pop_front();
      act = (it.sel == 0) ? int'(rdata) : (it.sel == 1) ? int'(match_evt) : int'(irq);
      checks++;
      if (act != it.exp) begin
        failures++;
        $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_out(input int sel, input int exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    #0.1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    step();
    wr_en = 0; addr = 2'd3;
  endtask

  task automatic bus_rd(input logic [1:0] a, input int exp, input string tag);
    rd_en = 1; addr = a;
    #0.5;
    expect_out(0, exp, tag);
    step();
    rd_en = 0; addr = 2'd3;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R12 reset state
    bus_rd(2'd0, 8'h00, "R12 compare low after reset");
    bus_rd(2'd1, 8'h00, "R12 staging after reset");
    bus_rd(2'd2, 8'h00, "R12 flag/enable after reset");
    expect_out(2, 0, "R12 irq after reset");

    // R7 / R8 normal mode direct write of 0x234
    bus_wr(2'd1, 8'h02);
    bus_wr(2'd0, 8'h34);
    bus_rd(2'd0, 8'h34, "R7 direct write visible");
    // R9 read copies active bits 9:8 into staging
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd0, 8'h34, "R9 read returns active low");
    bus_rd(2'd1, 8'h02, "R9 staging copy of bits 9:8");

    // R1 / R2 / R3 equality with enable off
    count = 10'h234;
    step();
    count = 10'h000;
    expect_out(1, 1, "R1 match pulse after equality");
    bus_rd(2'd2, 8'h01, "R2 flag set after equality");
    expect_out(2, 0, "R3 irq masked");
    expect_out(1, 0, "R1 pulse lasts one cycle");
    // R5 write with bit0=0 leaves flag, sets enable
    bus_wr(2'd2, 8'h02);
    expect_out(2, 1, "R3 irq with enable");
    bus_rd(2'd2, 8'h03, "R5 zero write leaves flag");

    // R4 acknowledge
    irq_ack = 1; step(); irq_ack = 0;
    expect_out(2, 0, "R4 irq after ack");
    bus_rd(2'd2, 8'h02, "R4 flag after ack");

    // R5 write one clears
    count = 10'h234; step(); count = 10'h000;
    bus_rd(2'd2, 8'h03, "R2 flag set again");
    bus_wr(2'd2, 8'h03);
    bus_rd(2'd2, 8'h02, "R5 write one clears");

    // R5 equality wins over a clear in the same cycle
    count = 10'h234;
    bus_wr(2'd2, 8'h03);
    count = 10'h000;
    bus_rd(2'd2, 8'h03, "R5 set wins over clear");
    irq_ack = 1; step(); irq_ack = 0;

    // R10 forced compare
    force_cmp = 1; step(); force_cmp = 0;
    expect_out(1, 1, "R10 forced pulse");
    expect_out(2, 0, "R10 forced no irq");
    bus_rd(2'd2, 8'h02, "R10 forced no flag");

    // R6 PWM mode, update at top
    pwm_en = 1; upd_sel = 0;
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'h55);
    bus_rd(2'd0, 8'h34, "R6 buffered write not active");
    at_bottom = 1; step(); at_bottom = 0;
    bus_rd(2'd0, 8'h34, "R6 other boundary ignored");
    at_top = 1; step(); at_top = 0;
    bus_rd(2'd0, 8'h55, "R6 top boundary loads");
    bus_rd(2'd1, 8'h00, "R9 staging copy after load");

    // R6 update at bottom
    upd_sel = 1;
    bus_wr(2'd1, 8'h01);
    bus_wr(2'd0, 8'h10);
    at_top = 1; step(); at_top = 0;
    bus_rd(2'd0, 8'h55, "R6 top ignored when bottom selected");
    at_bottom = 1; step(); at_bottom = 0;
    bus_rd(2'd0, 8'h10, "R6 bottom boundary loads");
    bus_rd(2'd1, 8'h01, "R8 upper bits of loaded value");

    // R11 write in the boundary cycle lands at the next boundary
    at_bottom = 1;
    bus_wr(2'd0, 8'h77);
    at_bottom = 0;
    bus_rd(2'd0, 8'h10, "R11 coinciding write deferred");
    at_bottom = 1; step(); at_bottom = 0;
    bus_rd(2'd0, 8'h77, "R11 lands at next boundary");

    // R1 equality on a PWM-loaded value 0x177
    count = 10'h177; step(); count = 10'h000;
    expect_out(1, 1, "R1 match on loaded value");
    expect_out(2, 1, "R3 irq on match");
    irq_ack = 1; step(); irq_ack = 0;

    // R7 back to normal mode: immediate
    pwm_en = 0;
    bus_wr(2'd1, 8'h03);
    bus_wr(2'd0, 8'hC8);
    bus_rd(2'd0, 8'hC8, "R7 immediate after leaving PWM");
    bus_rd(2'd1, 8'h03, "R8 staging holds bits 9:8");

    wait (sb.size() == 0);
    #1;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule